// File: doc/BRIEF.md
# Receive Holding Queue

This block sits between a serial deserializer and a register read port. The deserializer hands it one byte at a time, or a line-break indication. Software later drains the bytes through a read strobe, oldest first. The queue holds at most four bytes. It drives three outputs: a data-available status, a queue-full status, and an accept signal that throttles the upstream receiver.

A receiver-reset command drives a flush input, which discards every queued byte. A break event always stores a zero byte and raises a sticky break flag, even when the receiver is disabled. If the queue is already full, the zero byte replaces the newest entry and nothing is lost from the older ones. A separate clear input drops the break flag again.

Top module: `rx_hold_queue`

## Requirements
- R1: After reset, data_avail, queue_full and brk_flag are 0, and rd_data is 0x00.
- R2: Bytes are returned in arrival order, and at most 4 are held.
- R3: One clock edge after any byte is stored, data_avail is 1. One edge after the count reaches 4, queue_full is 1.
- R4: A push on push_valid is taken only when rx_en is 1 and queue_full is 0; otherwise it is ignored. can_accept equals rx_en AND NOT queue_full.
- R5: A read strobe on an empty queue loads 0x00 into rd_data and leaves the queue unchanged.
- R6: A read strobe on a non-empty queue loads the oldest byte into rd_data on that edge and removes it. It clears queue_full, and clears data_avail only when the count becomes 0. rd_data holds its value between strobes.
- R7: brk_evt stores 0x00 whatever rx_en is. A push_valid in the same cycle is dropped.
- R8: When brk_evt arrives with the queue full (after any same-cycle read), the 0x00 overwrites the newest entry and the count stays at 4.
- R9: flush empties the queue and clears data_avail and queue_full on the next edge. A read strobe in the same cycle still returns the oldest byte of the state before the flush.
- R10: A read and an accepted push in the same cycle leave the count unchanged, and the status flags follow that count.
- R11: brk_flag goes to 1 on the edge after brk_evt. It stays at 1 until brk_clr; when both arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enabled |
| push_valid | input | 1 | Normal received byte present |
| push_data | input | 8 | Received byte |
| brk_evt | input | 1 | Line-break event, stores 0x00 |
| flush | input | 1 | Receiver reset: discard all entries |
| rd_stb | input | 1 | Read strobe, pops the oldest byte |
| brk_clr | input | 1 | Clears the break flag |
| rd_data | output | 8 | Byte returned by the last read strobe |
| data_avail | output | 1 | Queue holds at least one byte |
| queue_full | output | 1 | Queue holds four bytes |
| can_accept | output | 1 | Upstream may deliver a normal byte |
| brk_flag | output | 1 | Sticky break indication |

## Verification
The bench targets these corner cases:
- A break on a full queue. A design that appends, or that overwrites the oldest slot instead of the newest, drains the wrong byte sequence.
- Reads on an empty queue. Returning stale data, or letting the count wrap, shows up at once on rd_data and data_avail.
- A read together with a push at full and at one entry. These catch a count that double-steps or a full flag that lags.
- A flush in the same cycle as a read, and a break racing a normal push. These expose the wrong priority.

A long mixed random run checks every output against a queue model on each cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    WR_NONE      = 2'd0,
    WR_APPEND    = 2'd1,
    WR_OVERWRITE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              rd_zero,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // plain synchronous write port, no reset, so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_zero ? '0 : mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             push_valid,
  input  logic             brk_evt,
  input  logic             flush,
  input  logic             rd_stb,
  output wr_kind_e         wr_kind,
  output logic [PTR_W-1:0] waddr,
  output logic [PTR_W-1:0] raddr,
  output logic             rd_empty,
  output logic             data_avail,
  output logic             queue_full,
  output logic             can_accept
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] rptr, wptr, rptr_nx, wptr_nx;
  logic [CNT_W-1:0] cnt, cnt_left, cnt_nx;
  logic             take, accept;

  always_comb begin
    take     = rd_stb && (cnt != '0);
    accept   = push_valid && rx_en && !queue_full && !brk_evt;
    cnt_left = cnt - {{(CNT_W-1){1'b0}}, take};
    wr_kind  = WR_NONE;
    if (!flush) begin
      if (brk_evt) wr_kind = (cnt_left == FULL_CNT) ? WR_OVERWRITE : WR_APPEND;
      else if (accept) wr_kind = WR_APPEND;
    end
    waddr   = (wr_kind == WR_OVERWRITE) ? ptr_dec(wptr) : wptr;
    raddr   = rptr;
    rd_empty = (cnt == '0);
    if (flush) begin
      cnt_nx  = '0;
      rptr_nx = '0;
      wptr_nx = '0;
    end else begin
      cnt_nx  = cnt_left + {{(CNT_W-1){1'b0}}, (wr_kind == WR_APPEND)};
      rptr_nx = take ? ptr_inc(rptr) : rptr;
      wptr_nx = (wr_kind == WR_APPEND) ? ptr_inc(wptr) : wptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      rptr       <= '0;
      wptr       <= '0;
      data_avail <= 1'b0;
      queue_full <= 1'b0;
    end else begin
      cnt        <= cnt_nx;
      rptr       <= rptr_nx;
      wptr       <= wptr_nx;
      data_avail <= (cnt_nx != '0);
      queue_full <= (cnt_nx == FULL_CNT);
    end
  end

  assign can_accept = rx_en && !queue_full;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);

  // R3
  full_has_data_chk: assert property (@(posedge clk) disable iff (rst)
    queue_full |-> data_avail);

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!data_avail && !queue_full));

  // R8
  brk_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_evt && queue_full && !rd_stb && !flush) |=> queue_full);

  // R5
  empty_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !data_avail && !push_valid && !brk_evt && !flush) |=> !data_avail);

  // R10
  rd_push_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && data_avail && accept && !flush) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              brk_evt,
  input  logic              flush,
  input  logic              rd_stb,
  input  logic              brk_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              queue_full,
  output logic              can_accept,
  output logic              brk_flag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  wr_kind_e          wr_kind;
  logic [PTR_W-1:0]  waddr, raddr;
  logic              rd_empty;
  logic [DATA_W-1:0] wdata;

  assign wdata = brk_evt ? '0 : push_data;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .push_valid (push_valid),
    .brk_evt    (brk_evt),
    .flush      (flush),
    .rd_stb     (rd_stb),
    .wr_kind    (wr_kind),
    .waddr      (waddr),
    .raddr      (raddr),
    .rd_empty   (rd_empty),
    .data_avail (data_avail),
    .queue_full (queue_full),
    .can_accept (can_accept)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_kind != WR_NONE),
    .waddr   (waddr),
    .wdata   (wdata),
    .rd_en   (rd_stb),
    .rd_zero (rd_empty),
    .raddr   (raddr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)          brk_flag <= 1'b0;
    else if (brk_evt) brk_flag <= 1'b1;
    else if (brk_clr) brk_flag <= 1'b0;
  end

  // R11
  brk_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> brk_flag);

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !data_avail) |=> (rd_data == '0));
endmodule

// File: tb/rx_hold_queue_tb.sv
module rx_hold_queue_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, push_valid = 1'b0, brk_evt = 1'b0;
  logic       flush = 1'b0, rd_stb = 1'b0, brk_clr = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic [7:0] rd_data;
  logic       data_avail, queue_full, can_accept, brk_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] q[$];
  logic [7:0] exp_rd = 8'h00;
  logic       exp_brk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hold_queue u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .push_valid(push_valid),
    .push_data(push_data), .brk_evt(brk_evt), .flush(flush),
    .rd_stb(rd_stb), .brk_clr(brk_clr), .rd_data(rd_data),
    .data_avail(data_avail), .queue_full(queue_full),
    .can_accept(can_accept), .brk_flag(brk_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rd_data", rd_data, exp_rd);
    chk(tag, "data_avail", data_avail, q.size() > 0);
    chk(tag, "queue_full", queue_full, q.size() == 4);
    chk(tag, "can_accept", can_accept, rx_en && (q.size() != 4));
    chk(tag, "brk_flag", brk_flag, exp_brk);
  endtask

  // inputs are applied at the falling edge; the model steps at the rising edge
  task automatic step(input string tag, input bit p, input logic [7:0] d,
                      input bit rd, input bit brk, input bit fl, input bit clr);
    int n;
    push_valid = p; push_data = d; rd_stb = rd; brk_evt = brk; flush = fl; brk_clr = clr;
    @(posedge clk);
    n = q.size();
    if (rd) exp_rd = (n > 0) ? q[0] : 8'h00;
    if (fl) q.delete();
    else begin
      if (rd && n > 0) void'(q.pop_front());
      if (brk) begin
        if (q.size() == 4) q[3] = 8'h00;
        else q.push_back(8'h00);
      end else if (p && rx_en && n != 4) q.push_back(d);
    end
    if (brk) exp_brk = 1'b1;
    else if (clr) exp_brk = 1'b0;
    @(negedge clk);
    push_valid = 0; rd_stb = 0; brk_evt = 0; flush = 0; brk_clr = 0;
    compare(tag);
  endtask

  task automatic push(input string tag, input logic [7:0] d);
    step(tag, 1, d, 0, 0, 0, 0);
  endtask

  task automatic pop(input string tag);
    step(tag, 0, 8'h00, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state straight after reset
    compare("R1");

    rx_en = 1'b1;
    // R2 / R3: fill to four, then drain in order
    push("R3", 8'hA1); push("R3", 8'hA2); push("R3", 8'hA3); push("R3", 8'hA4);
    // R4: full queue ignores further data
    push("R4", 8'hEE);
    pop("R2"); pop("R2"); pop("R2"); pop("R2");
    // R5: reads on an empty queue
    pop("R5"); pop("R5");
    // R4: disabled receiver ignores data
    rx_en = 1'b0;
    push("R4", 8'h55);
    pop("R4");
    rx_en = 1'b1;
    // R6: data_avail stays until the last byte leaves
    push("R6", 8'h11); push("R6", 8'h22);
    pop("R6"); pop("R6");
    // R7: break with the receiver disabled, and break racing a push
    rx_en = 1'b0;
    step("R7", 0, 8'h00, 0, 1, 0, 0);
    rx_en = 1'b1;
    step("R7", 1, 8'h77, 0, 1, 0, 0);
    pop("R7"); pop("R7"); pop("R7");
    // R11: clear, and set winning over clear
    step("R11", 0, 8'h00, 0, 0, 0, 1);
    step("R11", 0, 8'h00, 0, 1, 0, 1);
    step("R11", 0, 8'h00, 0, 0, 0, 1);
    pop("R11");
    // R8: break on a full queue replaces the newest entry
    push("R8", 8'hC1); push("R8", 8'hC2); push("R8", 8'hC3); push("R8", 8'hC4);
    step("R8", 0, 8'h00, 0, 1, 0, 0);
    pop("R8"); pop("R8"); pop("R8"); pop("R8"); pop("R8");
    // R8: break with a read on a full queue appends
    push("R8", 8'hD1); push("R8", 8'hD2); push("R8", 8'hD3); push("R8", 8'hD4);
    step("R8", 0, 8'h00, 1, 1, 0, 0);
    pop("R8"); pop("R8"); pop("R8"); pop("R8");
    // R10: read and push together
    push("R10", 8'h31);
    step("R10", 1, 8'h32, 1, 0, 0, 0);
    push("R10", 8'h33); push("R10", 8'h34); push("R10", 8'h35);
    step("R10", 1, 8'h36, 1, 0, 0, 0);
    pop("R10"); pop("R10"); pop("R10"); pop("R10");
    // R9: flush with a same-cycle read
    push("R9", 8'h41); push("R9", 8'h42); push("R9", 8'h43);
    step("R9", 0, 8'h00, 1, 0, 1, 0);
    pop("R9");
    // R2: mixed traffic
    for (int i = 0; i < 3000; i++) begin
      rx_en = ($urandom % 4) != 0;
      step("R2", ($urandom % 2) == 1, 8'($urandom), ($urandom % 3) == 0,
           ($urandom % 16) == 0, ($urandom % 32) == 0, ($urandom % 8) == 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule